// File: doc/BRIEF.md
# Credit-Based Transmit Flow-Control Gate

This block sits on the transmit side of a point-to-point link. It decides, cycle by cycle, whether a pending packet may leave. The decision rests on buffer credits that the receiver at the far end has advertised. Traffic is split into several independent types. Each type owns two credit classes: a header class, where every packet costs one credit, and a data class, where a packet costs the number of data credits it states.

The far end first advertises a starting allowance for each type. From then on it hands credits back as its buffers drain. The gate keeps two modular counters per class. The limit counter grows with every return. The consumed counter grows with every granted packet. Neither counter is ever compared directly against the other: the permission test looks only at the sign bit of their modular difference. Both counters can therefore wrap freely over a long run.

The requester holds a request, with its type and its data cost, until the grant output is high in that same cycle. The gate also publishes the consumed count of every class so that the rest of the transmitter can observe it.

Top module: `credit_gate`

## Requirements
- R1: A pulse on `initValid` loads `initHdr` and `initDat` as the limits of type `initType` and clears both of that type's consumed counts at the next clock edge. Other types keep their state. A request for the type being advertised in that same cycle is not granted.
- R2: When `grant` is high, the header consumed count of `reqType` rises by exactly 1 at the next edge, and its data consumed count rises by exactly `reqDat`.
- R3: `grant` is high in the same cycle as the request only when all of the following hold: `reqValid` is high, `reqType` is below the number of types, and each class of that type passes. A class passes if it is unlimited, or if (limit − (consumed + cost)) mod 2^N has its top bit clear, where N is 8 for the header class and 12 for the data class. The header cost is 1. After reset every class has a limit of 0, so nothing is granted before an advertisement. A receiver that frees no more than it received therefore never overflows.
- R4: Consumed and limit counters wrap modulo 2^N. Grant decisions stay correct after any number of wraps, as long as outstanding credit stays below 2^(N−1).
- R5: In a cycle with no grant and no advertisement, no consumed count changes.
- R6: A pulse on `retValid` adds `retHdr` and `retDat` to the limits of `retType` and leaves the consumed counts alone. If a return and a grant fall in the same cycle, both take effect. The grant in that cycle is decided on the limit as it was before the return.
- R7: A class that is advertised with the value 0 has unlimited credit and always passes. Its consumed count still advances on grants.
- R8: A packet is granted only when both classes of its type pass in the same cycle, and it then consumes both together. A data cost of 0 needs header credit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initValid | input | 1 | Advertisement strobe |
| initType | input | TYPE_W | Type being advertised |
| initHdr | input | HDR_W | Advertised header credits (0 = unlimited) |
| initDat | input | DAT_W | Advertised data credits (0 = unlimited) |
| retValid | input | 1 | Credit return strobe |
| retType | input | TYPE_W | Type receiving returned credits |
| retHdr | input | HDR_W | Header credits returned |
| retDat | input | DAT_W | Data credits returned |
| reqValid | input | 1 | Packet waiting to be sent |
| reqType | input | TYPE_W | Type of the waiting packet |
| reqDat | input | DAT_W-1 | Data credit cost of the waiting packet |
| grant | output | 1 | Packet may go this cycle |
| consHdr | output | NUM_TYPES*HDR_W | Header consumed counts, type t at bits [t*HDR_W +: HDR_W] |
| consDat | output | NUM_TYPES*DAT_W | Data consumed counts, type t at bits [t*DAT_W +: DAT_W] |

## Verification
The assertions rely on three properties of the inputs:
- Returned credits never exceed what the far end actually holds.
- Outstanding credit per class stays below half the counter range.
- A type is re-advertised only when it is drained, and never in the same cycle as a return to that type.

The stimulus enforces all three through a behavioural receiver. This receiver keeps its occupancy from the gate's actual grants and hands back only part of what it holds, after random delays. Advertised sizes are kept small against both counter widths. The reference model tracks unbounded totals of advertised, returned and consumed credit. As a result, counter wrap, same-cycle return and grant, and exact-fit boundaries are all compared against plain integer arithmetic rather than modular logic.

// File: rtl/credit_gate_pkg.sv
package credit_gate_pkg;

  // Strobes the control sends to the counter datapath each cycle.
  typedef struct packed {
    logic load;    // apply an advertisement
    logic credit;  // apply a credit return
    logic take;    // charge the requested packet
  } gate_strobe_t;

endpackage

// File: rtl/credit_counter.sv
// One credit class: modular limit, modular consumed count, unlimited flag.
module credit_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         credit,
  input  logic [W-1:0] creditAmt,
  input  logic         take,
  input  logic [W-1:0] takeAmt,
  input  logic [W-1:0] askAmt,
  output logic         pass,
  output logic [W-1:0] consumed
);

  logic [W-1:0] limitQ;
  logic [W-1:0] consQ;
  logic         unlimQ;
  logic [W-1:0] needed;
  logic [W-1:0] headroom;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ <= '0;
      consQ  <= '0;
      unlimQ <= 1'b0;
    end else if (load) begin
      limitQ <= loadVal;
      consQ  <= '0;
      unlimQ <= (loadVal == '0);
    end else begin
      if (credit) limitQ <= limitQ + creditAmt;
      if (take)   consQ  <= consQ + takeAmt;
    end
  end

  // Sign of the modular difference decides; the counters may wrap freely.
  always_comb begin
    needed   = consQ + askAmt;
    headroom = limitQ - needed;
    pass     = unlimQ | ~headroom[W-1];
  end

  assign consumed = consQ;

endmodule

// File: rtl/credit_datapath.sv
module credit_datapath
  import credit_gate_pkg::*;
#(
  parameter int NT = 3,
  parameter int HW = 8,
  parameter int DW = 12,
  parameter int TW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  gate_strobe_t    strobe,
  input  logic [TW-1:0]   initType,
  input  logic [HW-1:0]   initHdr,
  input  logic [DW-1:0]   initDat,
  input  logic [TW-1:0]   retType,
  input  logic [HW-1:0]   retHdr,
  input  logic [DW-1:0]   retDat,
  input  logic [TW-1:0]   reqType,
  input  logic [DW-2:0]   reqDat,
  output logic            hdrPass,
  output logic            datPass,
  output logic [NT*HW-1:0] consHdr,
  output logic [NT*DW-1:0] consDat
);

  localparam logic [HW-1:0] HDR_COST = HW'(1);

  logic [NT-1:0] hPassVec;
  logic [NT-1:0] dPassVec;
  logic [DW-1:0] datCost;

  assign datCost = {1'b0, reqDat};

  for (genvar t = 0; t < NT; t++) begin : g_type
    logic selLoad;
    logic selCredit;
    logic selTake;

    assign selLoad   = strobe.load   && (initType == TW'(t));
    assign selCredit = strobe.credit && (retType  == TW'(t));
    assign selTake   = strobe.take   && (reqType  == TW'(t));

    credit_counter #(.W(HW)) u_hdr (
      .clk       (clk),
      .rstN      (rstN),
      .load      (selLoad),
      .loadVal   (initHdr),
      .credit    (selCredit),
      .creditAmt (retHdr),
      .take      (selTake),
      .takeAmt   (HDR_COST),
      .askAmt    (HDR_COST),
      .pass      (hPassVec[t]),
      .consumed  (consHdr[t*HW +: HW])
    );

    credit_counter #(.W(DW)) u_dat (
      .clk       (clk),
      .rstN      (rstN),
      .load      (selLoad),
      .loadVal   (initDat),
      .credit    (selCredit),
      .creditAmt (retDat),
      .take      (selTake),
      .takeAmt   (datCost),
      .askAmt    (datCost),
      .pass      (dPassVec[t]),
      .consumed  (consDat[t*DW +: DW])
    );
  end

  // Pick the verdicts of the requested type; an out-of-range type never passes.
  always_comb begin
    hdrPass = 1'b0;
    datPass = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (reqType == TW'(t)) begin
        hdrPass = hPassVec[t];
        datPass = dPassVec[t];
      end
    end
  end

endmodule

// File: rtl/credit_control.sv
module credit_control
  import credit_gate_pkg::*;
#(
  parameter int TW = 2
) (
  input  logic          initValid,
  input  logic [TW-1:0] initType,
  input  logic          retValid,
  input  logic          reqValid,
  input  logic [TW-1:0] reqType,
  input  logic          hdrPass,
  input  logic          datPass,
  output logic          grant,
  output gate_strobe_t  strobe
);

  logic initSameType;

  always_comb begin
    initSameType  = initValid && (initType == reqType);
    grant         = reqValid && hdrPass && datPass && !initSameType;
    strobe.load   = initValid;
    strobe.credit = retValid;
    strobe.take   = grant;
  end

endmodule

// File: rtl/credit_gate.sv
module credit_gate
  import credit_gate_pkg::*;
#(
  parameter int NUM_TYPES = 3,
  parameter int HDR_W     = 8,
  parameter int DAT_W     = 12,
  localparam int TYPE_W   = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       initValid,
  input  logic [TYPE_W-1:0]          initType,
  input  logic [HDR_W-1:0]           initHdr,
  input  logic [DAT_W-1:0]           initDat,
  input  logic                       retValid,
  input  logic [TYPE_W-1:0]          retType,
  input  logic [HDR_W-1:0]           retHdr,
  input  logic [DAT_W-1:0]           retDat,
  input  logic                       reqValid,
  input  logic [TYPE_W-1:0]          reqType,
  input  logic [DAT_W-2:0]           reqDat,
  output logic                       grant,
  output logic [NUM_TYPES*HDR_W-1:0] consHdr,
  output logic [NUM_TYPES*DAT_W-1:0] consDat
);

  gate_strobe_t strobe;
  logic         hdrPass;
  logic         datPass;

  credit_control #(.TW(TYPE_W)) u_ctl (
    .initValid (initValid),
    .initType  (initType),
    .retValid  (retValid),
    .reqValid  (reqValid),
    .reqType   (reqType),
    .hdrPass   (hdrPass),
    .datPass   (datPass),
    .grant     (grant),
    .strobe    (strobe)
  );

  credit_datapath #(
    .NT (NUM_TYPES),
    .HW (HDR_W),
    .DW (DAT_W),
    .TW (TYPE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .initType (initType),
    .initHdr  (initHdr),
    .initDat  (initDat),
    .retType  (retType),
    .retHdr   (retHdr),
    .retDat   (retDat),
    .reqType  (reqType),
    .reqDat   (reqDat),
    .hdrPass  (hdrPass),
    .datPass  (datPass),
    .consHdr  (consHdr),
    .consDat  (consDat)
  );

endmodule

// File: rtl/credit_gate_check.sv
module credit_gate_check #(
  parameter int NT = 3,
  parameter int HW = 8,
  parameter int DW = 12,
  parameter int TW = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            initValid,
  input logic [TW-1:0]   initType,
  input logic            reqValid,
  input logic [TW-1:0]   reqType,
  input logic [DW-2:0]   reqDat,
  input logic            grant,
  input logic [NT*HW-1:0] consHdr,
  input logic [NT*DW-1:0] consDat
);

  logic [HW-1:0] hArr [NT];
  logic [DW-1:0] dArr [NT];

  for (genvar t = 0; t < NT; t++) begin : g_unpack
    assign hArr[t] = consHdr[t*HW +: HW];
    assign dArr[t] = consDat[t*DW +: DW];
  end

  logic          lastTake;
  logic          lastLoad;
  logic [TW-1:0] lastType;
  logic [TW-1:0] lastLoadType;
  logic [HW-1:0] lastH;
  logic [DW-1:0] lastD;
  logic [DW-2:0] lastCost;
  logic [HW-1:0] curH;
  logic [DW-1:0] curD;
  logic [HW-1:0] atTakeH;
  logic [DW-1:0] atTakeD;
  logic [HW-1:0] atLoadH;
  logic [DW-1:0] atLoadD;

  always_comb begin
    curH = '0; curD = '0; atTakeH = '0; atTakeD = '0; atLoadH = '0; atLoadD = '0;
    for (int t = 0; t < NT; t++) begin
      if (reqType == TW'(t))      begin curH    = hArr[t]; curD    = dArr[t]; end
      if (lastType == TW'(t))     begin atTakeH = hArr[t]; atTakeD = dArr[t]; end
      if (lastLoadType == TW'(t)) begin atLoadH = hArr[t]; atLoadD = dArr[t]; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastTake     <= 1'b0;
      lastLoad     <= 1'b0;
      lastType     <= '0;
      lastLoadType <= '0;
      lastH        <= '0;
      lastD        <= '0;
      lastCost     <= '0;
    end else begin
      lastTake     <= grant;
      lastLoad     <= initValid;
      lastType     <= reqType;
      lastLoadType <= initType;
      lastH        <= curH;
      lastD        <= curD;
      lastCost     <= reqDat;
    end
  end

  p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> reqValid);

  p_header_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    lastTake |-> (atTakeH == lastH + HW'(1)));

  p_data_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    lastTake |-> (atTakeD == lastD + {1'b0, lastCost}));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!lastTake && !lastLoad) |-> ($stable(consHdr) && $stable(consDat)));

  p_init_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    lastLoad |-> (atLoadH == '0 && atLoadD == '0));

endmodule

bind credit_gate credit_gate_check #(
  .NT (NUM_TYPES),
  .HW (HDR_W),
  .DW (DAT_W),
  .TW (TYPE_W)
) i_check (
  .clk       (clk),
  .rstN      (rstN),
  .initValid (initValid),
  .initType  (initType),
  .reqValid  (reqValid),
  .reqType   (reqType),
  .reqDat    (reqDat),
  .grant     (grant),
  .consHdr   (consHdr),
  .consDat   (consDat)
);

// File: tb/test_credit_gate.sv
module test_credit_gate;
  localparam int NT = 3;
  localparam int HW = 8;
  localparam int DW = 12;
  localparam int TW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rstN = 1'b0;
  logic            initValid = 1'b0;
  logic [TW-1:0]   initType = '0;
  logic [HW-1:0]   initHdr = '0;
  logic [DW-1:0]   initDat = '0;
  logic            retValid = 1'b0;
  logic [TW-1:0]   retType = '0;
  logic [HW-1:0]   retHdr = '0;
  logic [DW-1:0]   retDat = '0;
  logic            reqValid = 1'b0;
  logic [TW-1:0]   reqType = '0;
  logic [DW-2:0]   reqDat = '0;
  logic            grant;
  logic [NT*HW-1:0] consHdr;
  logic [NT*DW-1:0] consDat;

  credit_gate #(.NUM_TYPES(NT), .HDR_W(HW), .DAT_W(DW)) i_credit_gate (
    .clk(clk), .rstN(rstN),
    .initValid(initValid), .initType(initType), .initHdr(initHdr), .initDat(initDat),
    .retValid(retValid), .retType(retType), .retHdr(retHdr), .retDat(retDat),
    .reqValid(reqValid), .reqType(reqType), .reqDat(reqDat),
    .grant(grant), .consHdr(consHdr), .consDat(consDat)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Unbounded totals per type; the receiver occupancy follows actual grants.
  int  advH[NT], advD[NT], retH[NT], retD[NT], useH[NT], useD[NT];
  int  occH[NT], occD[NT];
  bit  unlH[NT], unlD[NT];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expectGrant();
    int t;
    bit okH, okD;
    if (!reqValid) return 1'b0;
    t = int'(reqType);
    if (t >= NT) return 1'b0;
    if (initValid && initType == reqType) return 1'b0;
    okH = unlH[t] || (advH[t] + retH[t] - useH[t] >= 1);
    okD = unlD[t] || (advD[t] + retD[t] - useD[t] >= int'(reqDat));
    return okH && okD;
  endfunction

  // Called just after a falling edge with inputs driven; ends on the next falling edge.
  task automatic step(string req);
    bit exp;
    #2;
    exp = expectGrant();
    check(grant == exp, req, "grant", int'(grant), int'(exp));
    for (int t = 0; t < NT; t++) begin
      check(int'(consHdr[t*HW +: HW]) == (useH[t] % (1 << HW)), "R2 R4 R5",
            "header consumed", int'(consHdr[t*HW +: HW]), useH[t] % (1 << HW));
      check(int'(consDat[t*DW +: DW]) == (useD[t] % (1 << DW)), "R2 R4 R5",
            "data consumed", int'(consDat[t*DW +: DW]), useD[t] % (1 << DW));
    end
    // Receiver side: credit handed back this cycle leaves its buffer.
    if (retValid) begin
      occH[retType] -= int'(retHdr);
      occD[retType] -= int'(retDat);
      retH[retType] += int'(retHdr);
      retD[retType] += int'(retDat);
    end
    if (grant && int'(reqType) < NT) begin
      occH[reqType] += 1;
      occD[reqType] += int'(reqDat);
      if (!unlH[reqType])
        check(occH[reqType] <= advH[reqType], "R3", "receiver header fill",
              occH[reqType], advH[reqType]);
      if (!unlD[reqType])
        check(occD[reqType] <= advD[reqType], "R3", "receiver data fill",
              occD[reqType], advD[reqType]);
    end
    if (exp) begin
      useH[reqType] += 1;
      useD[reqType] += int'(reqDat);
    end
    if (initValid) begin
      advH[initType] = int'(initHdr);
      advD[initType] = int'(initDat);
      unlH[initType] = (initHdr == '0);
      unlD[initType] = (initDat == '0);
      retH[initType] = 0; retD[initType] = 0;
      useH[initType] = 0; useD[initType] = 0;
      occH[initType] = 0; occD[initType] = 0;
    end
    @(negedge clk);
  endtask

  task automatic idleInputs();
    initValid = 1'b0; retValid = 1'b0; reqValid = 1'b0;
    retHdr = '0; retDat = '0; reqDat = '0;
  endtask

  task automatic advertise(int t, int h, int d);
    idleInputs();
    initValid = 1'b1; initType = TW'(t); initHdr = HW'(h); initDat = DW'(d);
    step("R1");
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin
      advH[t] = 0; advD[t] = 0; retH[t] = 0; retD[t] = 0;
      useH[t] = 0; useD[t] = 0; occH[t] = 0; occD[t] = 0;
      unlH[t] = 0; unlD[t] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state: no credit anywhere, even a zero-data request is refused (R3).
    reqValid = 1'b1; reqType = '0; reqDat = '0;
    step("R3 reset");
    reqType = TW'(2); reqDat = DW-1'(5);
    step("R3 reset");

    // Advertise: type1 header unlimited, type2 data unlimited (R7).
    advertise(0, 4, 32);
    advertise(1, 0, 16);
    advertise(2, 3, 0);

    // Random traffic with a draining receiver; long enough for counters to wrap (R4).
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int rt;
      idleInputs();
      reqValid = ($urandom_range(0, 3) != 0);
      reqType  = TW'($urandom_range(0, NT - 1));
      reqDat   = (DW-1)'($urandom_range(0, 12));
      if ($urandom_range(0, 2) == 0) begin
        rt = $urandom_range(0, NT - 1);
        if (occH[rt] > 0 || occD[rt] > 0) begin
          retValid = 1'b1;
          retType  = TW'(rt);
          retHdr   = unlH[rt] ? '0 : HW'($urandom_range(0, occH[rt]));
          retDat   = unlD[rt] ? '0 : DW'($urandom_range(0, occD[rt]));
        end
      end
      step("R3 R6 R7 R8");
    end

    // Drain type 0 completely, then re-advertise it with a request pending (R1).
    idleInputs();
    retValid = 1'b1; retType = '0; retHdr = HW'(occH[0]); retDat = DW'(occD[0]);
    step("R6");
    idleInputs();
    initValid = 1'b1; initType = '0; initHdr = HW'(2); initDat = DW'(10);
    reqValid = 1'b1; reqType = '0; reqDat = (DW-1)'(1);
    step("R1 same-type request");

    // Exact-fit boundary: 10 data credits fit, one more does not (R3).
    idleInputs(); reqValid = 1'b1; reqType = '0; reqDat = (DW-1)'(10);
    step("R3 exact fit");
    idleInputs(); reqValid = 1'b1; reqType = '0; reqDat = (DW-1)'(1);
    step("R3 one over");
    // Zero data cost needs only the last header credit (R8).
    idleInputs(); reqValid = 1'b1; reqType = '0; reqDat = '0;
    step("R8 header only");
    idleInputs(); reqValid = 1'b1; reqType = '0; reqDat = '0;
    step("R8 header exhausted");
    // Return and request together: decision uses pre-return limit, return still lands (R6).
    idleInputs(); reqValid = 1'b1; reqType = '0; reqDat = '0;
    retValid = 1'b1; retType = '0; retHdr = HW'(1); retDat = '0;
    step("R6 same cycle");
    idleInputs(); reqValid = 1'b1; reqType = '0; reqDat = '0;
    step("R6 after return");
    idleInputs();
    step("R5 idle");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule